// File: doc/BRIEF.md
# Host Type Detector for a Shared USB / PS/2 Connector

This block settles, once after power-up, which kind of host is attached to a connector whose two signal wires serve either as the low-speed USB pair or as the PS/2 clock and data pair. The D+ wire doubles as the PS/2 clock and the D- wire as the PS/2 data. The block never drives either wire. It controls only the enable of the USB pull-up on D-, and it works out the host type from the levels it reads on the wires.

All timing is counted on a one-microsecond tick. After reset the block first waits out a power and oscillator stabilization interval. It then holds the pull-up off for a further settling interval so that the host's resistors decide the wire levels. A USB host pulls both wires low. A PS/2 host pulls them high, though it may hold the clock low to inhibit the device.

The block next samples both wires at a fixed spacing over a window. A run of consecutive samples with either wire high identifies a PS/2 host. If the whole window stays low, the block switches the pull-up on and waits briefly. It then looks for the low-speed connect state, which is D+ low with D- high. The verdict is latched and a done strobe marks it. The block stays idle until the next reset, and the protocol engines downstream use the verdict.

Top module: `host_sense`

## Requirements
- R1: During reset and in the cycle after it, `pullup_en`, `done` and `result_usb` are all 0.
- R2: The first wire sample is taken `SAMPLE_TICKS` ticks after the end of the `TICKS_POR` + `TICKS_SETTLE` wait. Samples then follow every `SAMPLE_TICKS` ticks. With the wires high from the start, `done` therefore rises in the cycle after tick number `TICKS_POR + TICKS_SETTLE + SAMPLE_TICKS*HIGH_RUN`, counting from the first tick after reset.
- R3: When `HIGH_RUN` consecutive samples each see at least one wire at 1, the block reports PS/2 (`result_usb` = 0 with `done`) and never enables the pull-up. This holds whether both wires are high or only one of them is.
- R4: Any sample with both wires at 0 clears the count of consecutive high samples. A run of high samples that is one sample short of `HIGH_RUN`, followed by a low sample, therefore produces no decision.
- R5: If the window of `WINDOW_TICKS/SAMPLE_TICKS` samples ends without a PS/2 decision, `pullup_en` rises in the cycle after the last sample tick, which is tick `TICKS_POR + TICKS_SETTLE + WINDOW_TICKS`. The pull-up is enabled at most once.
- R6: `CONNECT_TICKS` ticks after the pull-up is enabled, the block checks the wires. If D+ reads 0 and D- reads 1, it reports USB (`result_usb` = 1 with `done`) and keeps `pullup_en` at 1.
- R7: If that connect check sees any other level pair, the block reports PS/2 and drops `pullup_en` in the same cycle that `done` rises.
- R8: `done` is high for exactly one cycle after reset. From then on, `result_usb` and `pullup_en` hold their values until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| line_p | input | 1 | Level of D+ (PS/2 clock), asynchronous |
| line_n | input | 1 | Level of D- (PS/2 data), asynchronous |
| pullup_en | output | 1 | Enables the USB pull-up on D- |
| result_usb | output | 1 | 1 = USB host, 0 = PS/2 host; valid from `done` |
| done | output | 1 | One-cycle strobe when the verdict is taken |

## Verification
The bench builds the block with a stabilization wait of 5 ticks, a settling wait of 4 ticks, a sample every 2 ticks, a 20-tick window (ten samples), a 3-tick connect wait and a run length of 4. It feeds a tick every four clocks. With these values the whole sequence ends within about 35 ticks, and the exact ticks of the decision and of the pull-up enable can be computed by hand. A wire pattern held for three sample spacings then lands exactly three samples whatever the phase, so the one-short run of R4 and the full run of R3 can both be placed precisely. The host's reply to the pull-up is modelled as a function of `pullup_en`, which brings both outcomes of the connect check within reach.

// File: rtl/host_sense_pkg.sv
// Shared types for the host type detector.
package host_sense_pkg;

    // Sequencer phases, in the order they are visited.
    typedef enum logic [2:0] {
        HS_POWER,
        HS_SETTLE,
        HS_SAMPLE,
        HS_CONNECT,
        HS_FINAL
    } hs_state_t;

endpackage

// File: rtl/hs_line_sync.sv
// Multi-stage synchronizer for a group of asynchronous wire levels.
// Assumes: inputs may change at any time; reset value of every stage is 0.
module hs_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the raw levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/hs_span_count.sv
// Tick interval counter: counts ticks and flags the tick that ends an
// interval of limit_m1+1 ticks, then wraps to zero by itself.
// Assumes: limit_m1 is steady while an interval is in progress.
module hs_span_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit_m1,
    output logic         last
);
    logic [W-1:0] cnt;

    assign last = tick && (cnt == limit_m1);

    // Advance on each tick, wrap at the end of the interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (last)     cnt <= '0;
        else if (tick)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hs_run_track.sv
// Counts consecutive samples in which the wires read high and flags the
// sample that completes a run of RUN.
// Assumes: sample is a one-cycle strobe; clr holds the count at zero.
module hs_run_track #(
    parameter int RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sample,
    input  logic hi,
    output logic hit
);
    localparam int RW = $clog2(RUN + 1);
    localparam logic [RW-1:0] RUN_M1 = RW'(RUN - 1);

    logic [RW-1:0] cnt;

    assign hit = sample && hi && (cnt == RUN_M1);

    // Extend the run on a high sample, restart it on a low one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (sample)   cnt <= hi ? cnt + 1'b1 : '0;
    end
endmodule

// File: rtl/host_sense.sv
// Power-up host type detector for a connector shared between low-speed USB
// and PS/2. Waits for stabilization and settling, samples both wires over a
// window, and then either declares PS/2 on a run of high samples or applies
// the D- pull-up and checks for the USB connect state.
// Assumes: us_tick is a one-cycle pulse; the wires are never driven here.
module host_sense #(
    parameter int TICKS_POR     = 128000,
    parameter int TICKS_SETTLE  = 10000,
    parameter int SAMPLE_TICKS  = 2,
    parameter int WINDOW_TICKS  = 1000,
    parameter int CONNECT_TICKS = 10,
    parameter int HIGH_RUN      = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_p,
    input  logic line_n,
    output logic pullup_en,
    output logic result_usb,
    output logic done
);
    import host_sense_pkg::*;

    localparam int LONG_A  = (TICKS_POR > TICKS_SETTLE) ? TICKS_POR : TICKS_SETTLE;
    localparam int LONG_B  = (CONNECT_TICKS > SAMPLE_TICKS) ? CONNECT_TICKS : SAMPLE_TICKS;
    localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
    localparam int CW      = $clog2(LONGEST + 1);
    localparam int NSAMP   = WINDOW_TICKS / SAMPLE_TICKS;
    localparam int SW      = $clog2(NSAMP + 1);

    localparam logic [CW-1:0] POR_M1  = CW'(TICKS_POR - 1);
    localparam logic [CW-1:0] SET_M1  = CW'(TICKS_SETTLE - 1);
    localparam logic [CW-1:0] SMP_M1  = CW'(SAMPLE_TICKS - 1);
    localparam logic [CW-1:0] CON_M1  = CW'(CONNECT_TICKS - 1);
    localparam logic [SW-1:0] LAST_SC = SW'(NSAMP - 1);

    hs_state_t    st;
    logic [1:0]   lines_s;
    logic         p_s, n_s;
    logic [CW-1:0] limit_m1;
    logic         span_last;
    logic         sample;
    logic         run_hit;
    logic [SW-1:0] sc;

    hs_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({line_p, line_n}),
        .dout (lines_s)
    );
    assign p_s = lines_s[1];
    assign n_s = lines_s[0];

    // Pick the interval length that belongs to the current phase.
    always_comb begin
        case (st)
            HS_POWER:   limit_m1 = POR_M1;
            HS_SETTLE:  limit_m1 = SET_M1;
            HS_SAMPLE:  limit_m1 = SMP_M1;
            HS_CONNECT: limit_m1 = CON_M1;
            default:    limit_m1 = '0;
        endcase
    end

    hs_span_count #(.W(CW)) u_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st == HS_FINAL),
        .tick    (us_tick),
        .limit_m1(limit_m1),
        .last    (span_last)
    );

    assign sample = (st == HS_SAMPLE) && span_last;

    hs_run_track #(.RUN(HIGH_RUN)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st != HS_SAMPLE),
        .sample(sample),
        .hi    (p_s | n_s),
        .hit   (run_hit)
    );

    // Phase sequencer, pull-up control and verdict latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= HS_POWER;
            pullup_en  <= 1'b0;
            result_usb <= 1'b0;
            done       <= 1'b0;
            sc         <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                HS_POWER: if (span_last) st <= HS_SETTLE;
                HS_SETTLE: begin
                    sc <= '0;
                    if (span_last) st <= HS_SAMPLE;
                end
                HS_SAMPLE: begin
                    if (run_hit) begin
                        result_usb <= 1'b0;
                        done       <= 1'b1;
                        st         <= HS_FINAL;
                    end else if (sample) begin
                        if (sc == LAST_SC) begin
                            pullup_en <= 1'b1;
                            st        <= HS_CONNECT;
                        end else begin
                            sc <= sc + 1'b1;
                        end
                    end
                end
                HS_CONNECT: begin
                    if (span_last) begin
                        done <= 1'b1;
                        st   <= HS_FINAL;
                        if (!p_s && n_s) result_usb <= 1'b1;
                        else             pullup_en  <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/host_sense_chk.sv
// Property checker for host_sense, attached to every instance by bind.
// Assumes: the same clock and synchronous active-low reset as the block.
module host_sense_chk (
    input logic clk,
    input logic rst_n,
    input logic pullup_en,
    input logic result_usb,
    input logic done
);
    logic fin;
    logic was_rst;

    // Remember that the verdict has been given since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    fin <= 1'b0;
        else if (done) fin <= 1'b1;
    end

    // Remember that the previous edge saw reset.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: outputs are quiet right after reset.
    always @(posedge clk) begin
        if (was_rst) begin
            p_reset_quiet_r1: assert (!pullup_en && !done && !result_usb)
                else $error("outputs active after reset");
        end
    end

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (!done && $stable(result_usb) && $stable(pullup_en)));

    p_usb_holds_pullup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        result_usb |-> pullup_en);

    p_ps2_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !result_usb) |-> !pullup_en);

    p_pullup_drop_at_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pullup_en) |-> done);
endmodule

bind host_sense host_sense_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pullup_en (pullup_en),
    .result_usb(result_usb),
    .done      (done)
);

// File: tb/host_sense_test.sv
// Bench for host_sense: a vector table of host behaviours, then directed
// reset cases. Ticks come every four clocks and are counted here.
module host_sense_test;
    localparam int POR = 5, SET = 4, SMP = 2, WIN = 20, CON = 3, RUN = 4;

    typedef struct packed {
        logic       pulse;    // 1: line_p high only for tick_no in [12, 12+2*run)
        logic       p_lvl;
        logic       n_lvl;
        logic [3:0] run;
        logic       ack_p;    // wire levels while pull-up is on
        logic       ack_n;
        logic       exp_usb;
        logic       exp_pu;
        logic [7:0] exp_tick;
    } vec_t;

    // Decision ticks: high from start 5+4+2*4 = 17; full window 5+4+20+3 = 32.
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd32}, // USB host (R6)
        '{1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd17}, // PS/2 idle (R3)
        '{1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd17}, // PS/2 clock inhibit (R3)
        '{1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd17}, // only D+ high (R3)
        '{1'b1, 1'b0, 1'b0, 4'd3, 1'b0, 1'b1, 1'b1, 1'b1, 8'd32}, // R4: run one short
        '{1'b1, 1'b0, 1'b0, 4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 8'd19}, // full run late (R3)
        '{1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd32}, // no connect (R7)
        '{1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd32}  // both high at check (R7)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic [1:0] div = 2'd0;
    int   tick_no = 0;
    logic line_p, line_n;
    logic pullup_en, result_usb, done;
    vec_t cur = '0;

    int total = 0, bad = 0;
    int pu_seen = 0, pu_tick = 0, done_cnt = 0, done_tick = 0;

    always #5 clk = ~clk;

    host_sense #(
        .TICKS_POR(POR), .TICKS_SETTLE(SET), .SAMPLE_TICKS(SMP),
        .WINDOW_TICKS(WIN), .CONNECT_TICKS(CON), .HIGH_RUN(RUN), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .line_p(line_p), .line_n(line_n),
        .pullup_en(pullup_en), .result_usb(result_usb), .done(done)
    );

    // Free-running tick every four clocks, and a tick count since reset.
    always @(posedge clk) begin
        div     <= div + 2'd1;
        us_tick <= (div == 2'd2);
        if (!rst_n)       tick_no <= 0;
        else if (us_tick) tick_no <= tick_no + 1;
    end

    // Host model: wire levels from the scenario, the tick count and the pull-up.
    always_comb begin
        if (pullup_en) begin
            line_p = cur.ack_p;
            line_n = cur.ack_n;
        end else if (cur.pulse) begin
            line_p = (tick_no >= 12) && (tick_no < 12 + 2 * int'(cur.run));
            line_n = 1'b0;
        end else begin
            line_p = cur.p_lvl;
            line_n = cur.n_lvl;
        end
    end

    // Observe outputs away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            pu_seen = 0; pu_tick = 0; done_cnt = 0; done_tick = 0;
        end else begin
            if (pullup_en && pu_seen == 0) begin
                pu_seen = 1;
                pu_tick = tick_no;
            end
            if (done) begin
                done_cnt  = done_cnt + 1;
                done_tick = tick_no;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        int n = 0;
        while (done_cnt == 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (done_cnt == 0) chk(1'b0, "watchdog R8", 0, 1);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        // R1: reset state.
        cur = VECS[0];
        do_reset();
        @(negedge clk);
        chk(pullup_en == 1'b0, "R1 pullup", int'(pullup_en), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(result_usb == 1'b0, "R1 result", int'(result_usb), 0);

        for (int i = 0; i < 8; i++) begin
            cur = VECS[i];
            do_reset();
            wait_done();
            chk(result_usb == cur.exp_usb, "R3 R4 R6 R7 verdict", int'(result_usb), int'(cur.exp_usb));
            chk(pu_seen == int'(cur.exp_pu), "R3 R5 pullup used", pu_seen, int'(cur.exp_pu));
            chk(done_tick == int'(cur.exp_tick), "R2 R5 decision tick", done_tick, int'(cur.exp_tick));
            chk(done_cnt == 1, "R8 single strobe", done_cnt, 1);
            chk(pullup_en == cur.exp_usb, "R6 R7 final pullup", int'(pullup_en), int'(cur.exp_usb));
            if (cur.exp_pu)
                chk(pu_tick == POR + SET + WIN, "R5 pullup tick", pu_tick, POR + SET + WIN);
        end

        // R8: held state stays put long after the verdict.
        cur = VECS[0];
        do_reset();
        wait_done();
        repeat (200) @(negedge clk);
        chk(result_usb == 1'b1 && pullup_en == 1'b1, "R8 held verdict", int'(result_usb), 1);
        chk(done_cnt == 1, "R8 no second strobe", done_cnt, 1);

        // R1: reset in the middle of the window, then a fresh run.
        cur = VECS[0];
        do_reset();
        while (tick_no < 20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(pullup_en == 1'b0 && done == 1'b0, "R1 mid-run reset", int'(pullup_en), 0);
        cur = VECS[1];
        rst_n = 1'b1;
        wait_done();
        chk(done_tick == 17, "R2 restart timing", done_tick, 17);
        chk(result_usb == 1'b0, "R3 restart verdict", int'(result_usb), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule